// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block sequences a processor core between normal operation and two low-power states. In the stopped state the core clock is gated and external bus requests are refused. In the dozing state the pipeline is frozen but the bus can still be handed to an external master. The core enters either state through a write to its configuration register. The same write interface also selects the clock divider for reduced-frequency operation.

While a low-power state is active, the block watches the wake sources: eight external interrupt lines, one peripheral interrupt, an active-low NMI and the reset. When a wake source arrives, it returns the core to normal operation. It also reports a one-cycle wake indication, which tells the exception logic either to vector to a handler or to resume at the next instruction. Before the core clock is gated, the write buffer is allowed to drain. A store that sets the stop bit from a badly aligned address is flagged.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, and for the first cycle after the internal reset releases, `wake_vld`=1 with `wake_cause`=0 (reset) and `wake_exc`=1. In that same window the block is in normal operation: `halt_bit`=0, `doze_bit`=0, `stall`=0, `core_clk_en`=1 and `rf_sel`=0.
- R2: In normal operation, a configuration write with `cfg_halt`=1 sets `halt_bit` and `stall` on the next edge. The halt bit wins over `cfg_doze` when both are set.
- R3: `halt_misalign` pulses for one cycle, on the same edge that enters the stopped state, when `cfg_addr_lo` (the low four bits of the store's address) is not 4'h8.
- R4: In normal operation, a configuration write with `cfg_doze`=1 and `cfg_halt`=0 sets `doze_bit` and `stall` on the next edge.
- R5: In either low-power state, `core_clk_en` stays 1 until `wb_empty` is sampled high at a clock edge. It is 0 from that edge on, and returns to 1 on the edge that wakes the core.
- R6: `busgnt` follows `busreq` combinationally in normal and dozing operation, and is 0 while `halt_bit`=1.
- R7: The stopped state is left only for NMI (`nmi_n`=0) or an enabled interrupt. A disabled interrupt leaves `halt_bit` at 1 and gives no wake pulse. A wake from the stopped state always has `wake_exc`=1.
- R8: Any interrupt, enabled or not, or NMI clears `doze_bit` and `stall` on the next edge. On that same edge, `wake_vld` pulses for exactly one cycle.
- R9: Wake causes are encoded 0 reset, 1 NMI, 2 enabled interrupt, 3 resume (disabled interrupt), and are prioritised in that order. `wake_exc`=1 for causes 0 to 2 and 0 for cause 3. `int_en` bit i enables `int_ext[i]`, and bit 8 enables `int_per`; a 1 in an enable bit means the interrupt is enabled.
- R10: `rf_sel` takes `cfg_rf` on the edge after any configuration write, in every state and whatever the value of `busreq`.
- R11: Interrupts and NMI during normal operation produce no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_halt | input | 1 | Stop-mode request bit of the write |
| cfg_doze | input | 1 | Doze-mode request bit of the write |
| cfg_rf | input | 2 | Clock divider field of the write |
| cfg_addr_lo | input | 4 | Low address bits of the writing store |
| int_ext | input | 8 | External interrupt lines |
| int_per | input | 1 | Peripheral interrupt |
| int_en | input | 9 | Interrupt enables, 1 = enabled |
| nmi_n | input | 1 | Active-low non-maskable interrupt |
| busreq | input | 1 | External bus-release request |
| wb_empty | input | 1 | Write buffer empty flag |
| core_clk_en | output | 1 | Core clock gate enable |
| stall | output | 1 | Pipeline freeze |
| busgnt | output | 1 | Bus grant to external master |
| halt_bit | output | 1 | Stop state active |
| doze_bit | output | 1 | Doze state active |
| wake_vld | output | 1 | Wake cause valid pulse |
| wake_cause | output | 2 | Wake cause code |
| wake_exc | output | 1 | 1 = take exception, 0 = resume |
| halt_misalign | output | 1 | Misaligned stop store flag |
| rf_sel | output | 2 | Clock divider select |

## Verification
A corrupted state register would show up at once as a wrong `stall`, `halt_bit`, `doze_bit` or `busgnt` level in the cycle after the corruption. A wrong wake arbitration would show up as a wrong cause or exception flag in the single cycle of the wake pulse. A gate flag that is stuck or set too early would show up as `core_clk_en` dropping while the write buffer still holds data, or staying high after it drains. The directed tests therefore sample these outputs on every edge around each entry and wake event.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_HALT = 2'd1,
    PM_DOZE = 2'd2
  } pm_state_e;

  typedef enum logic [1:0] {
    WK_RESET  = 2'd0,
    WK_NMI    = 2'd1,
    WK_IRQ    = 2'd2,
    WK_RESUME = 2'd3
  } wake_cause_e;

  localparam logic [3:0] HALT_ADDR_LO = 4'h8;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb #(
  parameter int N_INT = 8
) (
  input  logic [N_INT-1:0] int_ext,
  input  logic             int_per,
  input  logic [N_INT:0]   int_en,
  input  logic             nmi_n,
  output logic             nmi_req,
  output logic             unm_req,
  output logic             msk_req
);
  localparam int N_SRC = N_INT + 1;

  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] unm_vec;
  logic [N_SRC-1:0] msk_vec;

  assign req = {int_per, int_ext};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign unm_vec[i] = req[i] &  int_en[i];
    assign msk_vec[i] = req[i] & ~int_en[i];
  end

  assign nmi_req = ~nmi_n;
  assign unm_req = |unm_vec;
  assign msk_req = |msk_vec;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_INT = 8,
  parameter int RF_W  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_halt,
  input  logic             cfg_doze,
  input  logic [RF_W-1:0]  cfg_rf,
  input  logic [3:0]       cfg_addr_lo,
  input  logic [N_INT-1:0] int_ext,
  input  logic             int_per,
  input  logic [N_INT:0]   int_en,
  input  logic             nmi_n,
  input  logic             busreq,
  input  logic             wb_empty,
  output logic             core_clk_en,
  output logic             stall,
  output logic             busgnt,
  output logic             halt_bit,
  output logic             doze_bit,
  output logic             wake_vld,
  output logic [1:0]       wake_cause,
  output logic             wake_exc,
  output logic             halt_misalign,
  output logic [RF_W-1:0]  rf_sel
);
  logic rst_s_n;
  logic nmi_req, unm_req, msk_req;

  pm_state_e   state_q, state_d;
  wake_cause_e cause_q, cause_d;
  logic        vld_q, vld_d;
  logic        gate_q, gate_d;
  logic        mis_q, mis_d;
  logic [RF_W-1:0] rf_q;
  logic        rf_en;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pwr_wake_arb #(.N_INT(N_INT)) u_wake_arb (
    .int_ext (int_ext),
    .int_per (int_per),
    .int_en  (int_en),
    .nmi_n   (nmi_n),
    .nmi_req (nmi_req),
    .unm_req (unm_req),
    .msk_req (msk_req)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    vld_d   = 1'b0;
    mis_d   = 1'b0;
    gate_d  = gate_q;
    unique case (state_q)
      PM_RUN: begin
        gate_d = 1'b0;
        if (cfg_we && cfg_halt) begin
          state_d = PM_HALT;
          mis_d   = (cfg_addr_lo != HALT_ADDR_LO);
        end else if (cfg_we && cfg_doze) begin
          state_d = PM_DOZE;
        end
      end
      PM_HALT: begin
        if (nmi_req || unm_req) begin
          state_d = PM_RUN;
          vld_d   = 1'b1;
          cause_d = nmi_req ? WK_NMI : WK_IRQ;
          gate_d  = 1'b0;
        end else if (wb_empty) begin
          gate_d = 1'b1;
        end
      end
      PM_DOZE: begin
        if (nmi_req || unm_req || msk_req) begin
          state_d = PM_RUN;
          vld_d   = 1'b1;
          gate_d  = 1'b0;
          if (nmi_req)      cause_d = WK_NMI;
          else if (unm_req) cause_d = WK_IRQ;
          else              cause_d = WK_RESUME;
        end else if (wb_empty) begin
          gate_d = 1'b1;
        end
      end
      default: begin
        state_d = PM_RUN;
        gate_d  = 1'b0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= PM_RUN;
      cause_q <= WK_RESET;
      vld_q   <= 1'b1;
      gate_q  <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      vld_q   <= vld_d;
      gate_q  <= gate_d;
      mis_q   <= mis_d;
    end
  end

  // Divider select: loaded on any write, never waits on the bus
  assign rf_en = cfg_we;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   rf_q <= '0;
    else if (rf_en) rf_q <= cfg_rf;
  end

  assign halt_bit      = (state_q == PM_HALT);
  assign doze_bit      = (state_q == PM_DOZE);
  assign stall         = (state_q != PM_RUN);
  assign core_clk_en   = !((state_q != PM_RUN) && gate_q);
  assign busgnt        = busreq && (state_q != PM_HALT);
  assign wake_vld      = vld_q;
  assign wake_cause    = cause_q;
  assign wake_exc      = (cause_q != WK_RESUME);
  assign halt_misalign = mis_q;
  assign rf_sel        = rf_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int RF_W = 2
) (
  input logic            clk,
  input logic            rst_s_n,
  input logic            cfg_we,
  input logic [RF_W-1:0] cfg_rf,
  input logic            busgnt,
  input logic            halt_bit,
  input logic            doze_bit,
  input logic            stall,
  input logic            core_clk_en,
  input logic            wake_vld,
  input logic [1:0]      wake_cause,
  input logic            wake_exc,
  input logic            halt_misalign,
  input logic [RF_W-1:0] rf_sel
);
  p_halt_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_bit |-> !busgnt);

  p_gate_only_stalled_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !core_clk_en |-> stall);

  p_wake_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_vld |=> !wake_vld);

  p_wake_runs_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    wake_vld |-> (!halt_bit && !doze_bit && !stall));

  p_halt_exc_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_bit |=> (!wake_vld || wake_exc));

  p_resume_noexc_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wake_vld && wake_cause == 2'd3) |-> !wake_exc);

  p_misalign_in_halt_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    halt_misalign |-> halt_bit);

  p_rf_load_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    cfg_we |=> (rf_sel == $past(cfg_rf)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.RF_W(RF_W)) u_chk (
  .clk           (clk),
  .rst_s_n       (rst_s_n),
  .cfg_we        (cfg_we),
  .cfg_rf        (cfg_rf),
  .busgnt        (busgnt),
  .halt_bit      (halt_bit),
  .doze_bit      (doze_bit),
  .stall         (stall),
  .core_clk_en   (core_clk_en),
  .wake_vld      (wake_vld),
  .wake_cause    (wake_cause),
  .wake_exc      (wake_exc),
  .halt_misalign (halt_misalign),
  .rf_sel        (rf_sel)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       cfg_we, cfg_halt, cfg_doze;
  logic [1:0] cfg_rf;
  logic [3:0] cfg_addr_lo;
  logic [7:0] int_ext;
  logic       int_per;
  logic [8:0] int_en;
  logic       nmi_n, busreq, wb_empty;
  logic       core_clk_en, stall, busgnt, halt_bit, doze_bit;
  logic       wake_vld, wake_exc, halt_misalign;
  logic [1:0] wake_cause, rf_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_halt(cfg_halt),
    .cfg_doze(cfg_doze), .cfg_rf(cfg_rf), .cfg_addr_lo(cfg_addr_lo),
    .int_ext(int_ext), .int_per(int_per), .int_en(int_en), .nmi_n(nmi_n),
    .busreq(busreq), .wb_empty(wb_empty), .core_clk_en(core_clk_en),
    .stall(stall), .busgnt(busgnt), .halt_bit(halt_bit), .doze_bit(doze_bit),
    .wake_vld(wake_vld), .wake_cause(wake_cause), .wake_exc(wake_exc),
    .halt_misalign(halt_misalign), .rf_sel(rf_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_halt = 0; cfg_doze = 0; cfg_addr_lo = 4'h8;
    int_ext = '0; int_per = 0; nmi_n = 1; busreq = 0;
  endtask

  task automatic cfg_write(input logic h, input logic d, input logic [1:0] rf, input logic [3:0] a);
    cfg_we = 1; cfg_halt = h; cfg_doze = d; cfg_rf = rf; cfg_addr_lo = a;
    step();
    cfg_we = 0; cfg_halt = 0; cfg_doze = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle_inputs(); cfg_rf = 2'd0; int_en = '0; wb_empty = 0;
    repeat (3) step();
    chk("R1", "wake_vld in reset", wake_vld, 1);
    chk("R1", "cause in reset", wake_cause, 0);
    chk("R1", "exc in reset", wake_exc, 1);
    chk("R1", "stall in reset", stall, 0);
    chk("R1", "clk_en in reset", core_clk_en, 1);
    chk("R1", "rf_sel in reset", rf_sel, 0);
    chk("R1", "halt_bit in reset", halt_bit, 0);
    @(negedge clk); rst_n = 1;
    step(); step();
    chk("R1", "wake_vld first cycle", wake_vld, 1);
    step();
    chk("R1", "wake_vld after", wake_vld, 0);
  endtask

  task automatic t_doze_gate_resume();
    wb_empty = 0; int_en = '0;
    cfg_write(0, 1, 2'd0, 4'h0);
    chk("R4", "doze_bit", doze_bit, 1);
    chk("R4", "stall", stall, 1);
    chk("R5", "clk_en before drain", core_clk_en, 1);
    repeat (3) step();
    chk("R5", "clk_en still draining", core_clk_en, 1);
    wb_empty = 1; step();
    chk("R5", "clk_en after drain", core_clk_en, 0);
    busreq = 1; #1;
    chk("R6", "grant in doze", busgnt, 1);
    cfg_write(0, 0, 2'd3, 4'h0);
    chk("R10", "rf while bus released", rf_sel, 3);
    chk("R10", "still dozing", doze_bit, 1);
    busreq = 0;
    int_ext[2] = 1; step(); int_ext[2] = 0;
    chk("R8", "wake pulse", wake_vld, 1);
    chk("R8", "doze cleared", doze_bit, 0);
    chk("R8", "stall cleared", stall, 0);
    chk("R9", "resume cause", wake_cause, 3);
    chk("R9", "resume no exc", wake_exc, 0);
    chk("R5", "clk_en on wake", core_clk_en, 1);
    step();
    chk("R8", "pulse one cycle", wake_vld, 0);
  endtask

  task automatic t_halt();
    wb_empty = 1; int_en = 9'h0F0;
    cfg_write(1, 1, 2'd1, 4'h8);
    chk("R2", "halt wins", halt_bit, 1);
    chk("R2", "doze not set", doze_bit, 0);
    chk("R2", "stall", stall, 1);
    chk("R3", "aligned no flag", halt_misalign, 0);
    busreq = 1; #1;
    chk("R6", "no grant in halt", busgnt, 0);
    busreq = 0;
    int_ext[1] = 1; step(); step();
    chk("R7", "masked ignored", halt_bit, 1);
    chk("R7", "no pulse", wake_vld, 0);
    chk("R5", "gated in halt", core_clk_en, 0);
    int_ext[5] = 1; step(); int_ext = '0;
    chk("R7", "woke", halt_bit, 0);
    chk("R7", "exc", wake_exc, 1);
    chk("R9", "irq cause", wake_cause, 2);
    step();
  endtask

  task automatic t_misalign();
    cfg_write(1, 0, 2'd1, 4'h4);
    chk("R3", "flag", halt_misalign, 1);
    step();
    chk("R3", "flag one cycle", halt_misalign, 0);
    nmi_n = 0; step(); nmi_n = 1;
    chk("R9", "nmi cause", wake_cause, 1);
    step();
  endtask

  task automatic t_priority();
    int_en = 9'h100;
    cfg_write(0, 1, 2'd1, 4'h0);
    int_per = 1; int_ext[0] = 1; nmi_n = 0; step();
    chk("R9", "nmi over irq", wake_cause, 1);
    nmi_n = 1; int_per = 0; int_ext = '0; step();
    cfg_write(0, 1, 2'd1, 4'h0);
    int_per = 1; int_ext[0] = 1; step(); int_per = 0; int_ext = '0;
    chk("R9", "unmasked over masked", wake_cause, 2);
    chk("R9", "exc", wake_exc, 1);
    step();
  endtask

  task automatic t_run_ignore();
    int_ext = 8'hFF; int_per = 1; nmi_n = 0;
    step(); step();
    chk("R11", "no wake in run", wake_vld, 0);
    chk("R11", "no stall in run", stall, 0);
    busreq = 1; #1;
    chk("R6", "grant in run", busgnt, 1);
    idle_inputs();
    step();
  endtask

  initial begin
    t_reset();
    t_doze_gate_resume();
    t_halt();
    t_misalign();
    t_priority();
    t_run_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule